// File: doc/BRIEF.md
# Reset and Interrupt Entry Sequencer

This block is the exception-entry engine of a small 8-bit processor core. The core tells it when an instruction has finished. At that moment the sequencer looks at three request sources: a reset request, a non-maskable interrupt and a maskable interrupt. It then runs the entry sequence for the winning request. It saves the machine state on the stack through a byte-wide memory port, fetches a 16-bit vector and hands the core a new program counter, stack pointer and flag register.

The same engine also serves the return-from-interrupt instruction. When the core commands an unstack, the sequencer pulls the saved flag register, both accumulators, the index register and the program counter back off the stack. The core keeps its own copies of the registers. It drives them in as inputs and takes the updated values from the outputs in the cycle where `done` pulses.

Top module: `irq_entry_seq`

## Requirements
- R1: While `rstN` is low and after it rises, `done` and `memWe` are 0, and `pcOut`, `spOut`, `ccOut` and `iFlag` are 0 until a sequence completes.
- R2: Requests are evaluated only in a cycle where the block is idle and `instrDone` is 1. Reset wins over NMI, and NMI wins over IRQ. A boundary with no acceptable request produces no `done` and no memory write.
- R3: Reset entry performs no memory write and leaves `spOut` equal to `spIn`. It reads the vector high byte at 0xFFFE and the low byte at 0xFFFF, sets `iFlag`, and pulses `done` on the 3rd clock after the boundary cycle.
- R4: A falling edge on `nmiN` is latched and taken at the next boundary whatever the I flag (bit 4 of `ccIn`). The vector is read at 0xFFFC/0xFFFD. The latch clears when the entry starts, so holding `nmiN` low does not start a second entry.
- R5: IRQ (`irqReq` level) is taken only when bit 4 of `ccIn` is 0, and its vector is read at 0xFFF8/0xFFF9. When the request is masked nothing happens, and the still-asserted level is taken at a later boundary once the flag is 0.
- R6: NMI and IRQ entry write 7 bytes in this order: PC low, PC high, X low, X high, B, A, flags. The addresses are `spIn`, `spIn`-1, ..., `spIn`-6, and the final `spOut` is `spIn`-7.
- R7: Each push writes at the current stack pointer and then decrements it. `memWe` is high only during pushes, and interrupt entry pulses `done` on the 10th clock after the boundary cycle.
- R8: After NMI or IRQ entry, `ccOut` equals `ccIn` with bit 4 set and `iFlag` is 1, while the flag byte on the stack is the unmodified `ccIn`. `xOut`, `aOut` and `bOut` equal the inputs.
- R9: `rtiCmd` in an idle cycle without `instrDone` starts an unstack. The unstack reads `spIn`+1 through `spIn`+7 as flags, A, B, X high, X low, PC high, PC low, and the pull increments before each read. It leaves `spOut` = `spIn`+7, writes nothing, and pulses `done` on the 8th clock.
- R10: `done` is high for exactly one clock, and `rtiCmd` or `instrDone` arriving while a sequence runs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| instrDone | input | 1 | Instruction boundary strobe |
| rtiCmd | input | 1 | Start the return-from-interrupt unstack |
| resetReq | input | 1 | Processor reset request (level) |
| nmiN | input | 1 | Non-maskable interrupt, active low, edge-latched |
| irqReq | input | 1 | Maskable interrupt request (level) |
| pcIn | input | 16 | Current program counter |
| xIn | input | 16 | Current index register |
| aIn | input | 8 | Current accumulator A |
| bIn | input | 8 | Current accumulator B |
| spIn | input | 16 | Current stack pointer |
| ccIn | input | 8 | Current flag register, I flag at bit 4 |
| memAddr | output | 16 | Memory address |
| memWe | output | 1 | Memory write enable |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Memory read data, valid in the addressed cycle |
| pcOut | output | 16 | New program counter |
| xOut | output | 16 | Updated index register |
| aOut | output | 8 | Updated accumulator A |
| bOut | output | 8 | Updated accumulator B |
| spOut | output | 16 | Updated stack pointer |
| ccOut | output | 8 | Updated flag register |
| iFlag | output | 1 | Updated I flag |
| done | output | 1 | One-clock pulse: outputs hold the new state |

## Verification
Counting from the boundary cycle, `done` is due on clock 3 for reset, clock 10 for NMI or IRQ entry and clock 8 for an unstack. The seven stack writes land on clocks 1 through 7. The bench drives every input just after a falling edge and counts falling edges until `done` appears, then compares that count with the figure above. It reads the register outputs in that same `done` cycle and reads the recorded write log afterwards. It checks that `done` has dropped one edge later, and that an unaccepted boundary stays silent for twelve edges.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  // Width of the sequence step counter shared by control and datapath.
  localparam int IDX_W = 4;

  typedef enum logic [1:0] {
    VEC_RST = 2'd0,
    VEC_NMI = 2'd1,
    VEC_IRQ = 2'd2
  } vecSel_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_PUSH = 3'd1,
    S_VEC  = 3'd2,
    S_PULL = 3'd3,
    S_DONE = 3'd4
  } seqState_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic             capture;  // load working registers from the inputs
    logic             pushEn;   // write frame byte idx at SP, then SP-1
    logic             pullEn;   // SP+1, read into frame slot LAST-idx
    logic             vecEn;    // read vector byte idx (high byte first)
    logic             setI;     // raise the I flag
    logic [IDX_W-1:0] idx;      // step within the current phase
    vecSel_e          vecSel;   // which vector to fetch
  } strobe_t;

endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int FRAME_LEN = 7,
  parameter int VEC_LEN   = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    instrDone,
  input  logic    rtiCmd,
  input  logic    resetReq,
  input  logic    nmiN,
  input  logic    irqReq,
  input  logic    iMask,
  output strobe_t stb,
  output logic    done
);

  localparam logic [IDX_W-1:0] FRAME_LAST = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] VEC_LAST   = IDX_W'(VEC_LEN - 1);

  seqState_e        stateQ, stateD;
  vecSel_e          vecQ, vecD;
  logic [IDX_W-1:0] idxQ, idxD;
  logic             nmiPrevQ, nmiPendQ;

  logic isIdle, takeReset, takeNmi, takeIrq, takeRti, nmiFall;

  always_comb begin
    isIdle    = (stateQ == S_IDLE);
    takeReset = isIdle & instrDone & resetReq;
    takeNmi   = isIdle & instrDone & ~resetReq & nmiPendQ;
    takeIrq   = isIdle & instrDone & ~resetReq & ~nmiPendQ & irqReq & ~iMask;
    takeRti   = isIdle & ~instrDone & rtiCmd;
    nmiFall   = nmiPrevQ & ~nmiN;
  end

  always_comb begin
    stateD = stateQ;
    idxD   = idxQ;
    vecD   = vecQ;
    unique case (stateQ)
      S_IDLE: begin
        idxD = '0;
        if (takeReset) begin
          stateD = S_VEC;
          vecD   = VEC_RST;
        end else if (takeNmi) begin
          stateD = S_PUSH;
          vecD   = VEC_NMI;
        end else if (takeIrq) begin
          stateD = S_PUSH;
          vecD   = VEC_IRQ;
        end else if (takeRti) begin
          stateD = S_PULL;
        end
      end
      S_PUSH: begin
        if (idxQ == FRAME_LAST) begin
          stateD = S_VEC;
          idxD   = '0;
        end else begin
          idxD = idxQ + 1'b1;
        end
      end
      S_VEC: begin
        if (idxQ == VEC_LAST) begin
          stateD = S_DONE;
          idxD   = '0;
        end else begin
          idxD = idxQ + 1'b1;
        end
      end
      S_PULL: begin
        if (idxQ == FRAME_LAST) begin
          stateD = S_DONE;
          idxD   = '0;
        end else begin
          idxD = idxQ + 1'b1;
        end
      end
      S_DONE:  stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= S_IDLE;
      vecQ     <= VEC_RST;
      idxQ     <= '0;
      nmiPrevQ <= 1'b1;
      nmiPendQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      vecQ     <= vecD;
      idxQ     <= idxD;
      nmiPrevQ <= nmiN;
      // A fresh edge outranks the clear of the one being serviced.
      if (nmiFall) nmiPendQ <= 1'b1;
      else if (takeNmi) nmiPendQ <= 1'b0;
    end
  end

  always_comb begin
    stb.capture = takeReset | takeNmi | takeIrq | takeRti;
    stb.pushEn  = (stateQ == S_PUSH);
    stb.pullEn  = (stateQ == S_PULL);
    stb.vecEn   = (stateQ == S_VEC);
    stb.setI    = (stateQ == S_VEC) && (idxQ == '0);
    stb.idx     = idxQ;
    stb.vecSel  = vecQ;
    done        = (stateQ == S_DONE);
  end

endmodule

// File: rtl/irq_entry_dp.sv
module irq_entry_dp
  import irq_entry_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              DATA_W    = 8,
  parameter int              I_BIT     = 4,
  parameter logic [ADDR_W-1:0] VEC_RESET = 16'hFFFE,
  parameter logic [ADDR_W-1:0] VEC_NMI_A = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_IRQ_A = 16'hFFF8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] xIn,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] bIn,
  input  logic [ADDR_W-1:0] spIn,
  input  logic [DATA_W-1:0] ccIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] xOut,
  output logic [DATA_W-1:0] aOut,
  output logic [DATA_W-1:0] bOut,
  output logic [ADDR_W-1:0] spOut,
  output logic [DATA_W-1:0] ccOut
);

  localparam int PTR_BYTES = ADDR_W / DATA_W;
  localparam int FRAME_LEN = 2 * PTR_BYTES + 3;
  localparam int SLOT_B    = 2 * PTR_BYTES;
  localparam int SLOT_A    = SLOT_B + 1;
  localparam int SLOT_CC   = SLOT_B + 2;

  logic [ADDR_W-1:0] pcQ, xQ, spQ;
  logic [DATA_W-1:0] aQ, bQ, ccQ;
  logic [DATA_W-1:0] frame [FRAME_LEN];
  logic [IDX_W-1:0]  pullSlot, vecByte;
  logic [ADDR_W-1:0] vecBase;

  // Frame slot k is the k-th byte pushed.
  for (genvar g = 0; g < PTR_BYTES; g++) begin : g_frame
    assign frame[g]             = pcQ[g*DATA_W +: DATA_W];
    assign frame[PTR_BYTES + g] = xQ[g*DATA_W +: DATA_W];
  end
  assign frame[SLOT_B]  = bQ;
  assign frame[SLOT_A]  = aQ;
  assign frame[SLOT_CC] = ccQ;

  always_comb begin
    pullSlot = IDX_W'(FRAME_LEN - 1) - stb.idx;
    vecByte  = IDX_W'(PTR_BYTES - 1) - stb.idx;
    unique case (stb.vecSel)
      VEC_NMI: vecBase = VEC_NMI_A;
      VEC_IRQ: vecBase = VEC_IRQ_A;
      default: vecBase = VEC_RESET;
    endcase
  end

  always_comb begin
    memWe    = stb.pushEn;
    memWdata = stb.pushEn ? frame[stb.idx] : '0;
    if (stb.pushEn)      memAddr = spQ;
    else if (stb.pullEn) memAddr = spQ + ADDR_W'(1);
    else if (stb.vecEn)  memAddr = vecBase + ADDR_W'(stb.idx);
    else                 memAddr = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ <= '0;
      xQ  <= '0;
      spQ <= '0;
      aQ  <= '0;
      bQ  <= '0;
      ccQ <= '0;
    end else begin
      if (stb.capture) begin
        pcQ <= pcIn;
        xQ  <= xIn;
        spQ <= spIn;
        aQ  <= aIn;
        bQ  <= bIn;
        ccQ <= ccIn;
      end
      if (stb.pushEn) spQ <= spQ - ADDR_W'(1);
      if (stb.pullEn) begin
        spQ <= spQ + ADDR_W'(1);
        for (int k = 0; k < PTR_BYTES; k++) begin
          if (pullSlot == IDX_W'(k))             pcQ[k*DATA_W +: DATA_W] <= memRdata;
          if (pullSlot == IDX_W'(PTR_BYTES + k)) xQ[k*DATA_W +: DATA_W]  <= memRdata;
        end
        if (pullSlot == IDX_W'(SLOT_B))  bQ  <= memRdata;
        if (pullSlot == IDX_W'(SLOT_A))  aQ  <= memRdata;
        if (pullSlot == IDX_W'(SLOT_CC)) ccQ <= memRdata;
      end
      if (stb.vecEn) begin
        for (int k = 0; k < PTR_BYTES; k++) begin
          if (vecByte == IDX_W'(k)) pcQ[k*DATA_W +: DATA_W] <= memRdata;
        end
      end
      if (stb.setI) ccQ[I_BIT] <= 1'b1;
    end
  end

  assign pcOut = pcQ;
  assign xOut  = xQ;
  assign aOut  = aQ;
  assign bOut  = bQ;
  assign spOut = spQ;
  assign ccOut = ccQ;

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter int                I_BIT     = 4,
  parameter logic [ADDR_W-1:0] VEC_RESET = 16'hFFFE,
  parameter logic [ADDR_W-1:0] VEC_NMI_A = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_IRQ_A = 16'hFFF8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrDone,
  input  logic              rtiCmd,
  input  logic              resetReq,
  input  logic              nmiN,
  input  logic              irqReq,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] xIn,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] bIn,
  input  logic [ADDR_W-1:0] spIn,
  input  logic [DATA_W-1:0] ccIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] xOut,
  output logic [DATA_W-1:0] aOut,
  output logic [DATA_W-1:0] bOut,
  output logic [ADDR_W-1:0] spOut,
  output logic [DATA_W-1:0] ccOut,
  output logic              iFlag,
  output logic              done
);

  localparam int PTR_BYTES = ADDR_W / DATA_W;
  localparam int FRAME_LEN = 2 * PTR_BYTES + 3;

  strobe_t stb;

  irq_entry_ctrl #(
    .FRAME_LEN (FRAME_LEN),
    .VEC_LEN   (PTR_BYTES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instrDone (instrDone),
    .rtiCmd    (rtiCmd),
    .resetReq  (resetReq),
    .nmiN      (nmiN),
    .irqReq    (irqReq),
    .iMask     (ccIn[I_BIT]),
    .stb       (stb),
    .done      (done)
  );

  irq_entry_dp #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .I_BIT     (I_BIT),
    .VEC_RESET (VEC_RESET),
    .VEC_NMI_A (VEC_NMI_A),
    .VEC_IRQ_A (VEC_IRQ_A)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .pcIn     (pcIn),
    .xIn      (xIn),
    .aIn      (aIn),
    .bIn      (bIn),
    .spIn     (spIn),
    .ccIn     (ccIn),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWe    (memWe),
    .memWdata (memWdata),
    .pcOut    (pcOut),
    .xOut     (xOut),
    .aOut     (aOut),
    .bOut     (bOut),
    .spOut    (spOut),
    .ccOut    (ccOut)
  );

  assign iFlag = ccOut[I_BIT];

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] spOut,
  input logic              done,
  input logic              iFlag
);

  // R7: a push writes at the current stack pointer
  p_push_at_sp_r7: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr == spOut));

  // R7: the stack pointer drops by one after each push
  p_push_dec_r7: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> (spOut == ($past(spOut) - ADDR_W'(1))));

  // R10: done lasts a single clock
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: no write while the result is presented
  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memWe);

  // R8: an entry that stacked leaves the I flag set
  p_entry_masks_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(memWe, 3)) |-> iFlag);

endmodule

bind irq_entry_seq irq_entry_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .memWe   (memWe),
  .memAddr (memAddr),
  .spOut   (spOut),
  .done    (done),
  .iFlag   (iFlag)
);

// File: tb/irq_entry_seq_tb.sv
`timescale 1ns/1ps
module irq_entry_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrDone = 1'b0, rtiCmd = 1'b0, resetReq = 1'b0, nmiN = 1'b1, irqReq = 1'b0;
  logic [15:0] pcIn = '0, xIn = '0, spIn = 16'h0080;
  logic [7:0]  aIn = '0, bIn = '0, ccIn = '0;
  logic [15:0] memAddr, pcOut, xOut, spOut;
  logic        memWe, iFlag, done;
  logic [7:0]  memWdata, memRdata, aOut, bOut, ccOut;

  int checks = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  irq_entry_seq u_dut (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .rtiCmd(rtiCmd),
    .resetReq(resetReq), .nmiN(nmiN), .irqReq(irqReq),
    .pcIn(pcIn), .xIn(xIn), .aIn(aIn), .bIn(bIn), .spIn(spIn), .ccIn(ccIn),
    .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata), .memRdata(memRdata),
    .pcOut(pcOut), .xOut(xOut), .aOut(aOut), .bOut(bOut), .spOut(spOut),
    .ccOut(ccOut), .iFlag(iFlag), .done(done)
  );

  // Memory model: page-zero RAM plus an 8-byte vector area at the top.
  logic [7:0]  ram [256];
  logic [7:0]  vecMem [8];
  logic        bwe = 1'b0;
  logic [15:0] bAddr = '0;
  logic [7:0]  bData = '0;
  logic [15:0] wAddr [64];
  logic [7:0]  wData [64];
  int          wCnt = 0;

  assign memRdata = (memAddr >= 16'hFFF8) ? vecMem[memAddr[2:0]] : ram[memAddr[7:0]];

  always @(posedge clk) begin
    if (memWe) begin
      ram[memAddr[7:0]] <= memWdata;
      wAddr[wCnt % 64]  <= memAddr;
      wData[wCnt % 64]  <= memWdata;
      wCnt              <= wCnt + 1;
    end else if (bwe) begin
      ram[bAddr[7:0]] <= bData;
    end
  end

  bit nmiPendM = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] frameByte(input int k, input logic [15:0] pc, input logic [15:0] x,
                                           input logic [7:0] a, input logic [7:0] b, input logic [7:0] cc);
    case (k)
      0: return pc[7:0];
      1: return pc[15:8];
      2: return x[7:0];
      3: return x[15:8];
      4: return b;
      5: return a;
      default: return cc;
    endcase
  endfunction

  task automatic dropNmi(input bit hold);
    nmiN = 1'b0;
    @(negedge clk);
    nmiPendM = 1'b1;
    if (!hold) begin
      nmiN = 1'b1;
      @(negedge clk);
    end
  endtask

  // Pulse instrDone with the current inputs and check the outcome.
  task automatic boundary(input bit pokeRti);
    int expK, cnt, base, expCnt;
    logic [15:0] pc0, x0, sp0, va, expPc;
    logic [7:0] a0, b0, cc0;
    string tg;
    bit seen;
    expK = resetReq ? 1 : nmiPendM ? 2 : (irqReq && !ccIn[4]) ? 3 : 0;
    pc0 = pcIn; x0 = xIn; sp0 = spIn; a0 = aIn; b0 = bIn; cc0 = ccIn;
    base = wCnt;
    instrDone = 1'b1;
    @(negedge clk);
    instrDone = 1'b0;
    cnt = 1;
    if (expK == 0) begin
      seen = 1'b0;
      repeat (12) begin
        if (done) seen = 1'b1;
        @(negedge clk);
      end
      tg = (irqReq && ccIn[4]) ? "R5 masked irq" : "R2 no request";
      chk(tg, {31'd0, seen}, 32'd0);
      chk({tg, " writes"}, wCnt - base, 32'd0);
      return;
    end
    while (!done && cnt < 40) begin
      rtiCmd = (pokeRti && cnt == 2);
      @(negedge clk);
      cnt++;
    end
    rtiCmd = 1'b0;
    va     = (expK == 1) ? 16'hFFFE : (expK == 2) ? 16'hFFFC : 16'hFFF8;
    expPc  = {vecMem[va[2:0]], vecMem[va[2:0] + 3'd1]};
    tg     = (expK == 1) ? "R3 reset" : (expK == 2) ? "R4 nmi" : "R5 irq";
    expCnt = (expK == 1) ? 3 : 10;
    chk({tg, " R7 done latency"}, cnt, expCnt);
    chk({tg, " R2 vector pc"}, pcOut, expPc);
    chk({tg, " R8 iFlag"}, iFlag, 1);
    chk({tg, " R8 ccOut"}, ccOut, cc0 | 8'h10);
    chk({tg, " R8 xOut"}, xOut, x0);
    chk({tg, " R8 ab"}, {aOut, bOut}, {a0, b0});
    if (expK == 1) begin
      chk("R3 reset sp", spOut, sp0);
      chk("R3 reset writes", wCnt - base, 0);
    end else begin
      chk({tg, " R6 sp"}, spOut, sp0 - 16'd7);
      chk({tg, " R6 writes"}, wCnt - base, 7);
      for (int k = 0; k < 7; k++) begin
        chk({tg, " R6 push addr"}, wAddr[(base + k) % 64], sp0 - 16'(k));
        chk({tg, " R6 push data"}, wData[(base + k) % 64], frameByte(k, pc0, x0, a0, b0, cc0));
      end
    end
    if (expK == 2) nmiPendM = 1'b0;
    @(negedge clk);
    chk("R10 done pulse", done, 0);
  endtask

  task automatic rti(input logic [15:0] sp0, input logic [15:0] pcE, input logic [15:0] xE,
                     input logic [7:0] aE, input logic [7:0] bE, input logic [7:0] ccE, input bit preload);
    int cnt, base;
    if (preload) begin
      for (int k = 0; k < 7; k++) begin
        bwe   = 1'b1;
        bAddr = sp0 + 16'd7 - 16'(k);
        bData = frameByte(k, pcE, xE, aE, bE, ccE);
        @(negedge clk);
      end
      bwe = 1'b0;
    end
    spIn = sp0;
    base = wCnt;
    rtiCmd = 1'b1;
    @(negedge clk);
    rtiCmd = 1'b0;
    cnt = 1;
    while (!done && cnt < 40) begin
      @(negedge clk);
      cnt++;
    end
    chk("R9 rti latency", cnt, 8);
    chk("R9 rti pc", pcOut, pcE);
    chk("R9 rti x", xOut, xE);
    chk("R9 rti ab", {aOut, bOut}, {aE, bE});
    chk("R9 rti cc", ccOut, ccE);
    chk("R9 rti iFlag", iFlag, ccE[4]);
    chk("R9 rti sp", spOut, sp0 + 16'd7);
    chk("R9 rti writes", wCnt - base, 0);
    @(negedge clk);
    chk("R10 rti done pulse", done, 0);
  endtask

  task automatic randRegs();
    pcIn = 16'($urandom);
    xIn  = 16'($urandom);
    aIn  = 8'($urandom);
    bIn  = 8'($urandom);
    ccIn = {2'b11, 6'($urandom)};
    spIn = 16'h0010 + 16'($urandom % 224);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [15:0] pcS, xS, spS;
    logic [7:0]  aS, bS, ccS;
    void'($urandom(32'h5EED));
    for (int k = 0; k < 8; k++) vecMem[k] = 8'($urandom);
    repeat (3) @(negedge clk);
    chk("R1 reset done", done, 0);
    chk("R1 reset we", memWe, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle outputs", {pcOut, spOut}, 32'd0);
    chk("R1 idle cc", {ccOut, iFlag}, 0);

    // R2: boundary without request
    randRegs();
    boundary(1'b0);

    // R5: masked IRQ stays pending, then is taken once I is 0
    randRegs();
    ccIn[4] = 1'b1;
    irqReq  = 1'b1;
    boundary(1'b0);
    ccIn[4] = 1'b0;
    boundary(1'b0);
    irqReq = 1'b0;

    // R4: NMI ignores I; a held low level does not retrigger
    randRegs();
    ccIn[4] = 1'b1;
    dropNmi(1'b1);
    boundary(1'b0);
    boundary(1'b0);
    nmiN = 1'b1;
    @(negedge clk);

    // R2: priority reset > NMI > IRQ
    randRegs();
    ccIn[4] = 1'b0;
    irqReq  = 1'b1;
    dropNmi(1'b0);
    resetReq = 1'b1;
    boundary(1'b0);
    resetReq = 1'b0;
    boundary(1'b0);
    boundary(1'b0);
    irqReq = 1'b0;

    // R9: round trip through the stack; R10: rtiCmd during entry ignored
    randRegs();
    ccIn[4] = 1'b0;
    irqReq  = 1'b1;
    pcS = pcIn; xS = xIn; aS = aIn; bS = bIn; ccS = ccIn; spS = spIn;
    boundary(1'b1);
    irqReq = 1'b0;
    rti(spOut, pcS, xS, aS, bS, ccS, 1'b0);
    chk("R9 round trip sp", spOut, spS);

    // Random mix
    for (int it = 0; it < 60; it++) begin
      int r;
      for (int k = 0; k < 8; k++) vecMem[k] = 8'($urandom);
      randRegs();
      r = int'($urandom % 8);
      resetReq = (r == 0);
      if (r == 1 || r == 2) dropNmi(1'b0);
      irqReq = 1'($urandom);
      boundary(($urandom % 4) == 0);
      resetReq = 1'b0;
      irqReq   = 1'b0;
      if (($urandom % 3) == 0) begin
        randRegs();
        rti(spIn, 16'($urandom), 16'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 1'b1);
      end
    end

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule